// File: doc/BRIEF.md
# Soft-Ramp Zero-Cross Volume Control

This block attenuates a stereo pair of signed PCM samples. Each channel takes an 8-bit attenuation code in 0.5 dB units and a mute request. The block keeps a current attenuation per channel in 1/8 dB units and moves it toward the requested value. Each move can be restricted to a signal zero crossing so that no audible click is produced. The applied gain comes from a small octave table indexed by the current attenuation, and a multiplier scales each sample.

Two enables choose how the attenuation moves:

| Soft step | Zero-cross gate | Movement |
|---|---|---|
| on | on | one 1/8 dB step per crossing |
| on | off | one step on every sample |
| off | on | the whole change at once, at a crossing |
| off | off | the change takes effect at once |

A crossing watchdog forces a pending change through if the signal stays on one side of zero for too long. A link input makes channel B use channel A's attenuation code. Mute drives the target to the deepest attenuation, and once that is reached the output is an exact zero.

Top module: `soft_ramp_volume`

## Requirements
- R1: During and directly after reset, outValid is 0 and outA and outB are 0; the current attenuation of both channels starts at 0, and the previous-sample sign of both channels starts non-negative.
- R2: An output sample equals floor(x * G(a) / 65536), where x is the signed input and a is the channel's attenuation after the update made on that sample. G(a) = T[a mod 48] >> (a div 48), with T[0] = 65536 and T[k+1] = floor(T[k] * 64596 / 65536).
- R3: outValid is high exactly in the cycle after a cycle with sampleValid high. When sampleValid is low, outA and outB keep their values and no attenuation changes.
- R4: The target attenuation of a channel is 4 times its 8-bit code, in 1/8 dB units. When linkAB is 1, channel B uses volA and volB is ignored.
- R5: With rampEn=1 and zcEn=1, a channel whose attenuation differs from its target moves one unit toward the target on a sample that is a zero crossing, and holds on any other sample.
- R6: A sample is a zero crossing for its channel if it equals zero, or if its sign differs from the sign of that channel's previous accepted sample.
- R7: With zcEn=1, a change that stays pending for 512 consecutive samples without a crossing is applied on the 512th sample. The count restarts after every applied change.
- R8: With rampEn=1 and zcEn=0, the attenuation moves one unit toward the target on every sample.
- R9: With rampEn=0 and zcEn=1, the attenuation jumps all the way to the target on a crossing sample, or when the R7 limit is reached.
- R10: With rampEn=0 and zcEn=0, the attenuation equals the target on the sample where the target is presented.
- R11: A muted channel has a target of 1020. While the channel is muted and its attenuation equals 1020, its output is exactly 0.
- R12: The attenuation never exceeds 1020. When rampEn is 1, it changes by at most one unit per sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A new stereo sample pair is present |
| sampleA | input | DATA_W | Channel A sample, two's complement |
| sampleB | input | DATA_W | Channel B sample, two's complement |
| volA | input | 8 | Channel A attenuation code, 0.5 dB units |
| volB | input | 8 | Channel B attenuation code, 0.5 dB units |
| muteA | input | 1 | Mute request, channel A |
| muteB | input | 1 | Mute request, channel B |
| linkAB | input | 1 | Channel B follows volA |
| rampEn | input | 1 | Move in single 1/8 dB steps |
| zcEn | input | 1 | Apply changes only at zero crossings |
| outValid | output | 1 | Output pair valid |
| outA | output | DATA_W | Attenuated channel A sample |
| outB | output | DATA_W | Attenuated channel B sample |

## Verification
Two things can land on the same sample: the expiry of the crossing watchdog and a genuine zero crossing. The bench provokes this with a run of 511 same-sign samples after a target change, followed by a sign flip on the 512th. The result passes only if the output shows exactly one 1/8 dB step and not two. A separate run without the flip confirms that the watchdog alone steps on the 512th sample, and not on the 511th.

// File: rtl/vol_pkg.sv
package vol_pkg;
  // attenuation code width and fractional sub-steps per code
  localparam int VOL_W = 8;
  localparam int SUB_W = 2;
  localparam int ATT_W = VOL_W + SUB_W;
  localparam logic [ATT_W-1:0] ATT_MAX = {{VOL_W{1'b1}}, {SUB_W{1'b0}}};

  // gain is unsigned with GAIN_W-1 fraction bits, unity = 2^(GAIN_W-1)
  localparam int GAIN_W = 17;
  // sub-steps per halving of amplitude (48 x 0.125 dB = 6 dB)
  localparam int OCT_STEPS = 48;
  // 2^(-1/48) with 16 fraction bits
  localparam longint STEP_MUL = 64596;

  typedef struct packed {
    logic             load;
    logic             silence;
    logic [ATT_W-1:0] att;
  } gainCmd_t;

  function automatic logic [GAIN_W-1:0] octaveGain(input int idx);
    longint g;
    g = longint'(1) <<< (GAIN_W - 1);
    for (int k = 0; k < idx; k++) g = (g * STEP_MUL) >>> (GAIN_W - 1);
    return GAIN_W'(g);
  endfunction
endpackage

// File: rtl/vol_ramp_ctrl.sv
module vol_ramp_ctrl
  import vol_pkg::*;
#(
  parameter int TIMEOUT = 512
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic [ATT_W-1:0] target,
  input  logic             muteReq,
  input  logic             rampEn,
  input  logic             zcEn,
  input  logic             zcHit,
  output gainCmd_t         cmd,
  output logic [ATT_W-1:0] attNow
);
  localparam int CNT_W = $clog2(TIMEOUT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] waitCnt, waitNext;
  logic [ATT_W-1:0] goal, attStep, attNext;
  logic             pending, gateOpen;

  always_comb begin
    goal     = muteReq ? ATT_MAX : target;
    pending  = (attNow != goal);
    attStep  = (attNow < goal) ? attNow + 1'b1 : attNow - 1'b1;
    gateOpen = zcHit || (waitCnt == CNT_LAST);
    attNext  = attNow;
    waitNext = '0;
    if (!rampEn && !zcEn) begin
      attNext = goal;
    end else if (!zcEn) begin
      if (pending) attNext = attStep;
    end else if (pending) begin
      if (gateOpen) attNext = rampEn ? attStep : goal;
      else          waitNext = waitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      attNow  <= '0;
      waitCnt <= '0;
    end else if (sampleValid) begin
      attNow  <= attNext;
      waitCnt <= waitNext;
    end
  end

  always_comb begin
    cmd.load    = sampleValid;
    cmd.att     = attNext;
    cmd.silence = muteReq && (attNext == ATT_MAX);
  end
endmodule

// File: rtl/vol_gain_path.sv
module vol_gain_path
  import vol_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  gainCmd_t                 cmd,
  output logic                     zcHit,
  output logic signed [DATA_W-1:0] sampleOut
);
  localparam int IDX_W  = $clog2(OCT_STEPS);
  localparam int SH_W   = $clog2(int'(ATT_MAX) / OCT_STEPS + 1);
  localparam int PROD_W = DATA_W + GAIN_W + 1;

  logic [GAIN_W-1:0] octRom [OCT_STEPS];

  for (genvar k = 0; k < OCT_STEPS; k++) begin : g_rom
    localparam logic [GAIN_W-1:0] ENTRY = octaveGain(k);
    assign octRom[k] = ENTRY;
  end

  logic                     prevNeg;
  logic [IDX_W-1:0]         romIdx;
  logic [SH_W-1:0]          shAmt;
  logic [GAIN_W-1:0]        gain;
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    romIdx = IDX_W'(int'(cmd.att) % OCT_STEPS);
    shAmt  = SH_W'(int'(cmd.att) / OCT_STEPS);
    gain   = octRom[romIdx] >> shAmt;
    prod   = sampleIn * $signed({1'b0, gain});
    zcHit  = (sampleIn == '0) || (sampleIn[DATA_W-1] != prevNeg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevNeg   <= 1'b0;
      sampleOut <= '0;
    end else if (cmd.load) begin
      prevNeg   <= sampleIn[DATA_W-1];
      sampleOut <= cmd.silence ? '0 : DATA_W'(prod >>> (GAIN_W - 1));
    end
  end
endmodule

// File: rtl/soft_ramp_volume.sv
module soft_ramp_volume
  import vol_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TIMEOUT = 512
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleValid,
  input  logic signed [DATA_W-1:0] sampleA,
  input  logic signed [DATA_W-1:0] sampleB,
  input  logic [VOL_W-1:0]         volA,
  input  logic [VOL_W-1:0]         volB,
  input  logic                     muteA,
  input  logic                     muteB,
  input  logic                     linkAB,
  input  logic                     rampEn,
  input  logic                     zcEn,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outA,
  output logic signed [DATA_W-1:0] outB
);
  localparam int CH = 2;

  logic signed [DATA_W-1:0] chSample [CH];
  logic signed [DATA_W-1:0] chOut    [CH];
  logic [ATT_W-1:0]         chTarget [CH];
  logic [ATT_W-1:0]         chAtt    [CH];
  logic                     chMute   [CH];
  logic                     chZc     [CH];
  gainCmd_t                 chCmd    [CH];
  logic [ATT_W-1:0]         attCh0, attCh1;

  always_comb begin
    chSample[0] = sampleA;
    chSample[1] = sampleB;
    chMute[0]   = muteA;
    chMute[1]   = muteB;
    chTarget[0] = {volA, {SUB_W{1'b0}}};
    chTarget[1] = {(linkAB ? volA : volB), {SUB_W{1'b0}}};
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    vol_ramp_ctrl #(.TIMEOUT(TIMEOUT)) u_ctrl (
      .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
      .target(chTarget[c]), .muteReq(chMute[c]),
      .rampEn(rampEn), .zcEn(zcEn), .zcHit(chZc[c]),
      .cmd(chCmd[c]), .attNow(chAtt[c])
    );
    vol_gain_path #(.DATA_W(DATA_W)) u_path (
      .clk(clk), .rstN(rstN), .sampleIn(chSample[c]),
      .cmd(chCmd[c]), .zcHit(chZc[c]), .sampleOut(chOut[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= sampleValid;
  end

  assign outA   = chOut[0];
  assign outB   = chOut[1];
  assign attCh0 = chAtt[0];
  assign attCh1 = chAtt[1];
endmodule

// File: rtl/soft_ramp_volume_chk.sv
module soft_ramp_volume_chk
  import vol_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     sampleValid,
  input logic [VOL_W-1:0]         volA,
  input logic                     muteA,
  input logic                     rampEn,
  input logic                     zcEn,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outA,
  input logic signed [DATA_W-1:0] outB,
  input logic [ATT_W-1:0]         attA,
  input logic [ATT_W-1:0]         attB
);
  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> outValid);
  assert_valid_drops_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !outValid);
  assert_hold_outputs_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> ($stable(outA) && $stable(outB) && $stable(attA) && $stable(attB)));
  assert_att_range_R12: assert property (@(posedge clk) disable iff (!rstN)
    (attA <= ATT_MAX) && (attB <= ATT_MAX));
  assert_single_step_R12: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && rampEn) |=> ((attA == $past(attA)) || (attA == $past(attA) + 1'b1)
                                 || (attA + 1'b1 == $past(attA))));
  assert_immediate_R10: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !rampEn && !zcEn && !muteA) |=> (attA == {$past(volA), {SUB_W{1'b0}}}));
  assert_mute_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(muteA) && attA == ATT_MAX) |-> (outA == '0));
endmodule

bind soft_ramp_volume soft_ramp_volume_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .volA(volA), .muteA(muteA),
  .rampEn(rampEn), .zcEn(zcEn), .outValid(outValid), .outA(outA), .outB(outB),
  .attA(attCh0), .attB(attCh1)
);

// File: tb/tb_soft_ramp_volume.sv
module tb_soft_ramp_volume;
  logic clk = 1'b0;
  always #2.5ns clk = ~clk;

  logic rstN, sampleValid, muteA, muteB, linkAB, rampEn, zcEn, outValid;
  logic signed [15:0] sampleA, sampleB, outA, outB;
  logic [7:0] volA, volB;

  soft_ramp_volume dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleA(sampleA), .sampleB(sampleB),
    .volA(volA), .volB(volB), .muteA(muteA), .muteB(muteB), .linkAB(linkAB),
    .rampEn(rampEn), .zcEn(zcEn), .outValid(outValid), .outA(outA), .outB(outB)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int mAtt [2];
  bit mNeg [2];
  int mWait [2];

  function automatic longint gainOf(int a);
    longint t = 65536;
    for (int k = 0; k < a % 48; k++) t = (t * 64596) >>> 16;
    return t >>> (a / 48);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference behaviour of one channel for one accepted sample
  function automatic int modelChan(int ch, int x);
    int v, tgt, stepd;
    bit m, zc;
    v = (ch == 1 && !linkAB) ? int'(volB) : int'(volA);
    m = (ch == 0) ? muteA : muteB;
    tgt = m ? 1020 : 4 * v;
    zc = (x == 0) || ((x < 0) != mNeg[ch]);
    stepd = (mAtt[ch] < tgt) ? mAtt[ch] + 1 : mAtt[ch] - 1;
    if (!rampEn && !zcEn) begin
      mAtt[ch] = tgt; mWait[ch] = 0;
    end else if (!zcEn) begin
      if (mAtt[ch] != tgt) mAtt[ch] = stepd;
      mWait[ch] = 0;
    end else if (mAtt[ch] != tgt) begin
      if (zc || mWait[ch] == 511) begin
        mAtt[ch] = rampEn ? stepd : tgt; mWait[ch] = 0;
      end else mWait[ch]++;
    end else mWait[ch] = 0;
    mNeg[ch] = (x < 0);
    if (m && mAtt[ch] == 1020) return 0;
    return int'((longint'(x) * gainOf(mAtt[ch])) >>> 16);
  endfunction

  task automatic sendPair(int xa, int xb, string tag);
    int ea, eb;
    @(negedge clk);
    sampleA = 16'(xa); sampleB = 16'(xb); sampleValid = 1'b1;
    ea = modelChan(0, xa); eb = modelChan(1, xb);
    @(negedge clk);
    sampleValid = 1'b0;
    check({tag, " valid"}, longint'(outValid), 1);
    check({tag, " outA"}, longint'(outA), longint'(ea));
    check({tag, " outB"}, longint'(outB), longint'(eb));
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R3 watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    logic signed [15:0] holdA;
    void'($urandom(32'd4242));
    rstN = 0; sampleValid = 0; sampleA = 0; sampleB = 0; volA = 0; volB = 0;
    muteA = 0; muteB = 0; linkAB = 0; rampEn = 0; zcEn = 0;
    for (int c = 0; c < 2; c++) begin mAtt[c] = 0; mNeg[c] = 0; mWait[c] = 0; end
    repeat (3) @(negedge clk);
    check("R1 reset valid", longint'(outValid), 0);
    check("R1 reset outA", longint'(outA), 0);
    check("R1 reset outB", longint'(outB), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 after reset valid", longint'(outValid), 0);

    // R1 R6: start at 0 dB, positive start sign gives no crossing
    rampEn = 1; zcEn = 1; volA = 40; volB = 40;
    sendPair(12345, 23456, "R1 R6 first sample");
    check("R1 unattenuated", longint'(outA), 12345);
    for (int i = 0; i < 4; i++) sendPair(1000 + i, 2000, "R5 no crossing hold");
    sendPair(-1000, 0, "R6 sign flip and zero");
    sendPair(500, 0, "R6 flip back");
    check("R5 two steps", longint'(outA), (longint'(500) * gainOf(2)) >>> 16);

    // R3: outputs hold across gap
    holdA = outA;
    repeat (5) @(negedge clk);
    check("R3 hold valid", longint'(outValid), 0);
    check("R3 hold outA", longint'(outA), longint'(holdA));

    // R10 immediate, R4 link
    rampEn = 0; zcEn = 0; volA = 100; volB = 7; linkAB = 1;
    sendPair(30000, 30000, "R10 R4 linked");
    check("R4 link B uses A", longint'(outB), (longint'(30000) * gainOf(400)) >>> 16);
    linkAB = 0;
    sendPair(30000, 30000, "R4 unlinked");
    check("R4 own code B", longint'(outB), (longint'(30000) * gainOf(28)) >>> 16);

    // R9 jump at crossing
    rampEn = 0; zcEn = 1; volA = 10; volB = 3;
    for (int i = 0; i < 5; i++) sendPair(2000, 2000, "R9 wait");
    sendPair(-20000, -20000, "R9 jump");
    check("R9 full jump", longint'(outA), (longint'(-20000) * gainOf(40)) >>> 16);

    // R8 ramp every sample
    rampEn = 1; zcEn = 0; volA = 0; volB = 0;
    for (int i = 0; i < 45; i++) sendPair(3000 + i, -3000, "R8 ramp down");

    // R7 watchdog alone
    rampEn = 0; zcEn = 0; volA = 0; volB = 0;
    sendPair(30000, 30000, "R7 settle");
    rampEn = 1; zcEn = 1; volA = 1; volB = 1;
    for (int i = 0; i < 511; i++) sendPair(30000, 30000, "R7 before limit");
    check("R7 no step at 511", longint'(outA), 30000);
    sendPair(30000, 30000, "R7 limit");
    check("R7 step at 512", longint'(outA), (longint'(30000) * gainOf(1)) >>> 16);
    // R7 watchdog and crossing on the same sample: one step only
    for (int i = 0; i < 511; i++) sendPair(30000, 30000, "R7 R5 before coincide");
    sendPair(-30000, -30000, "R7 R5 coincide");
    check("R7 R5 single step", longint'(outA), (longint'(-30000) * gainOf(2)) >>> 16);

    // R11 mute ramp to full attenuation
    rampEn = 1; zcEn = 0; muteA = 1;
    for (int i = 0; i < 1025; i++) sendPair(32767, 32767, "R11 mute ramp");
    check("R11 exact zero", longint'(outA), 0);
    muteA = 0; volA = 0;
    for (int i = 0; i < 30; i++) sendPair(-32768, 100, "R11 unmute ramp");

    // random phase over all modes
    for (int seg = 0; seg < 70; seg++) begin
      int kind;
      rampEn = 1'($urandom); zcEn = 1'($urandom); linkAB = 1'($urandom);
      volA = 8'($urandom); volB = 8'($urandom);
      muteA = ($urandom % 8) == 0; muteB = ($urandom % 8) == 0;
      kind = $urandom % 3;
      for (int i = 0; i < 40; i++) begin
        int xa, xb;
        if (kind == 0) begin
          xa = int'($signed(16'($urandom))); xb = int'($signed(16'($urandom)));
        end else if (kind == 1) begin
          xa = int'($urandom % 5) - 2; xb = int'($urandom % 5) - 2;
        end else begin
          xa = int'($urandom % 32767) + 1; xb = -(int'($urandom % 32767) + 1);
        end
        sendPair(xa, xb, "R2 R4 R5 R8 R9 R10 R12 random");
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule